// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

This block is the delivery unit for one processor inside a multiprocessor interrupt controller. It tracks, for each of its sources, whether the source is queued for this processor (raised) and whether the processor is currently servicing it (in service). Source configuration, routing and address decode sit outside the block. The block reads each source's priority, vector, sense type and active flag from that storage. It reports changes to the active and pending flags back as one-cycle pulses.

A source that routing sends to this processor arrives as a delivery request. The request is queued only if its priority beats the processor's task-priority threshold and the source is not already queued. The interrupt line to the processor rises when the new priority beats the best priority already queued. An acknowledge read picks the best queued source: highest priority, with the lowest index winning a tie. It returns that source's vector, or the spurious vector if the queue is empty or the entry has gone stale. An end-of-interrupt write retires the highest-priority source in service. It raises the line again if a queued source outranks the highest priority still in service.

An acknowledge and an end-of-interrupt in the same cycle act as the acknowledge alone. Delivery requests in that cycle are still evaluated against the queue as it stood before the acknowledge.

Top module: `irqarb_cpu`

## Requirements
- R1: After reset the interrupt line and `ack_vld_o` are low, the task priority reads 15, the spurious vector reads 0xFF, and nothing is raised or in service.
- R2: A delivery request from source i is queued only when its 4-bit priority is strictly greater than the task priority. An accepted request pulses `act_set_o[i]` in the cycle after the request; a rejected one leaves it low.
- R3: A delivery request from a source whose raised bit is already set is dropped and produces no `act_set_o` pulse.
- R4: The interrupt line rises in the cycle after an accepted delivery whose priority is strictly greater than the best raised priority before it. An empty raised set counts as priority -1. An accepted delivery of equal or lower priority does not raise the line.
- R5: The best raised entry is the one with the highest priority. Among equal priorities the lowest source index wins.
- R6: Each acknowledge pulses `ack_vld_o` one cycle later. With nothing raised, the vector returned is the current spurious vector.
- R7: If the best raised source has its active flag low, or its priority no longer exceeds the task priority, the acknowledge returns the spurious vector, pulses `act_clr_o` for it and clears its raised bit.
- R8: Otherwise the acknowledge returns the source's 8-bit vector, clears its raised bit and sets its in-service bit.
- R9: An acknowledged edge-sensitive source (`src_level` = 0) gets pulses on both `act_clr_o` and `pend_clr_o`. A level-sensitive source (`src_level` = 1) that is validly acknowledged gets neither.
- R10: An acknowledge drops the interrupt line in the next cycle unless a delivery in the same cycle raises it again.
- R11: End-of-interrupt clears the in-service bit with the highest priority (lowest index on a tie). It raises the line when the best raised priority is strictly greater than the highest priority still in service, where an empty set counts as -1.
- R12: A task-priority write loads 4 bits and a spurious-vector write loads 8 bits. Each is visible on `tpr_o` / `spur_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dlv_req | input | N | Per-source delivery request from routing |
| src_prio | input | N*4 | Packed per-source priority |
| src_vec | input | N*8 | Packed per-source vector |
| src_level | input | N | Per-source sense: 1 level, 0 edge |
| src_active | input | N | Per-source active flag from source storage |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 4 | Task-priority write data |
| spur_we | input | 1 | Spurious-vector write strobe |
| spur_wdata | input | 8 | Spurious-vector write data |
| ack_req | input | 1 | Acknowledge read strobe |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| irq_o | output | 1 | Interrupt line to the processor |
| ack_vld_o | output | 1 | Acknowledge result valid |
| ack_vec_o | output | 8 | Acknowledge result vector |
| act_set_o | output | N | Pulse: set source active flag |
| act_clr_o | output | N | Pulse: clear source active flag |
| pend_clr_o | output | N | Pulse: clear source pending flag |
| tpr_o | output | 4 | Current task priority |
| spur_o | output | 8 | Current spurious vector |

## Verification
A wrong raised set shows up as a wrong vector or an unexpected spurious vector on the next acknowledge. It can also show up as a missing or extra `act_set_o` pulse one cycle after a repeated delivery. A wrong in-service set only shows up later, when an end-of-interrupt does or does not raise `irq_o` in the following cycle. For that reason the end-of-interrupt sequences are built so that retiring the wrong entry changes the line level. A bad tie-break or a bad priority comparison appears as a reordered vector sequence across back-to-back acknowledges.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

    // Outcome of one acknowledge access
    typedef enum logic [1:0] {
        ACK_NONE  = 2'd0,
        ACK_EMPTY = 2'd1,
        ACK_STALE = 2'd2,
        ACK_TAKEN = 2'd3
    } ack_kind_e;

    // True when a candidate priority beats an optional incumbent (empty = -1)
    function automatic logic prio_beats(input logic [3:0] cand,
                                        input logic       inc_found,
                                        input logic [3:0] inc_prio);
        return !inc_found || (cand > inc_prio);
    endfunction

endpackage

// File: rtl/irqarb_pick.sv
module irqarb_pick #(
    parameter int N  = 16,
    parameter int PW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio_flat,
    output logic            found,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   prio
);

    // Linear scan: a later index replaces the choice only on strictly greater priority,
    // so the lowest index wins among equals.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        prio  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || (prio_flat[i*PW +: PW] > prio))) begin
                found = 1'b1;
                idx   = IW'(i);
                prio  = prio_flat[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/irqarb_accept.sv
module irqarb_accept #(
    parameter int N  = 16,
    parameter int PW = 4
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio_flat,
    input  logic [PW-1:0]   tpr,
    input  logic [N-1:0]    raised,
    input  logic            best_found,
    input  logic [PW-1:0]   best_prio,
    output logic [N-1:0]    accept,
    output logic            raise_line
);

    logic [N-1:0] beats;

    for (genvar g = 0; g < N; g++) begin : g_src
        logic [PW-1:0] p;
        assign p         = prio_flat[g*PW +: PW];
        assign accept[g] = req[g] && (p > tpr) && !raised[g];
        assign beats[g]  = accept[g] && (!best_found || (p > best_prio));
    end

    assign raise_line = |beats;

endmodule

// File: rtl/irqarb_cpu.sv
module irqarb_cpu #(
    parameter int          N        = 16,
    parameter int          PW       = 4,
    parameter int          VW       = 8,
    parameter logic [3:0]  TPR_RST  = 4'd15,
    parameter logic [7:0]  SPUR_RST = 8'hFF,
    localparam int         IW       = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    dlv_req,
    input  logic [N*PW-1:0] src_prio,
    input  logic [N*VW-1:0] src_vec,
    input  logic [N-1:0]    src_level,
    input  logic [N-1:0]    src_active,
    input  logic            tpr_we,
    input  logic [PW-1:0]   tpr_wdata,
    input  logic            spur_we,
    input  logic [VW-1:0]   spur_wdata,
    input  logic            ack_req,
    input  logic            eoi_req,
    output logic            irq_o,
    output logic            ack_vld_o,
    output logic [VW-1:0]   ack_vec_o,
    output logic [N-1:0]    act_set_o,
    output logic [N-1:0]    act_clr_o,
    output logic [N-1:0]    pend_clr_o,
    output logic [PW-1:0]   tpr_o,
    output logic [VW-1:0]   spur_o
);
    import irqarb_pkg::*;

    typedef struct packed {
        logic [N-1:0]  raised;
        logic [N-1:0]  insvc;
        logic [PW-1:0] tpr;
        logic [VW-1:0] spur;
        logic          irq;
        logic          ack_vld;
        logic [VW-1:0] ack_vec;
        logic [N-1:0]  act_set;
        logic [N-1:0]  act_clr;
        logic [N-1:0]  pend_clr;
    } state_t;

    state_t st_d, st_q;
    ack_kind_e ack_kind;

    // Best raised entry
    logic          rb_found;
    logic [IW-1:0] rb_idx;
    logic [PW-1:0] rb_prio;
    // Highest in-service entry
    logic          is_found;
    logic [IW-1:0] is_idx;
    logic [PW-1:0] is_prio;
    // Highest in-service entry once the top one is retired
    logic [N-1:0]  is_mask, rem_cand;
    logic          rem_found;
    logic [IW-1:0] rem_idx;
    logic [PW-1:0] rem_prio;
    // Delivery filter
    logic [N-1:0]  accept;
    logic          dlv_raise;

    irqarb_pick #(.N(N), .PW(PW)) u_pick_raised (
        .cand(st_q.raised), .prio_flat(src_prio),
        .found(rb_found), .idx(rb_idx), .prio(rb_prio)
    );

    irqarb_pick #(.N(N), .PW(PW)) u_pick_insvc (
        .cand(st_q.insvc), .prio_flat(src_prio),
        .found(is_found), .idx(is_idx), .prio(is_prio)
    );

    assign is_mask  = is_found ? (N'(1) << is_idx) : '0;
    assign rem_cand = st_q.insvc & ~is_mask;

    irqarb_pick #(.N(N), .PW(PW)) u_pick_remain (
        .cand(rem_cand), .prio_flat(src_prio),
        .found(rem_found), .idx(rem_idx), .prio(rem_prio)
    );

    irqarb_accept #(.N(N), .PW(PW)) u_accept (
        .req(dlv_req), .prio_flat(src_prio), .tpr(st_q.tpr),
        .raised(st_q.raised), .best_found(rb_found), .best_prio(rb_prio),
        .accept(accept), .raise_line(dlv_raise)
    );

    // Classify the acknowledge against the current best raised entry
    always_comb begin
        if (!ack_req)
            ack_kind = ACK_NONE;
        else if (!rb_found)
            ack_kind = ACK_EMPTY;
        else if (!src_active[rb_idx] || (rb_prio <= st_q.tpr))
            ack_kind = ACK_STALE;
        else
            ack_kind = ACK_TAKEN;
    end

    always_comb begin
        st_d          = st_q;
        st_d.ack_vld  = 1'b0;
        st_d.act_set  = accept;
        st_d.act_clr  = '0;
        st_d.pend_clr = '0;
        st_d.raised   = st_q.raised | accept;

        if (tpr_we)  st_d.tpr  = tpr_wdata;
        if (spur_we) st_d.spur = spur_wdata;

        if (ack_kind != ACK_NONE) begin
            st_d.ack_vld = 1'b1;
            st_d.irq     = 1'b0;
            case (ack_kind)
                ACK_EMPTY: st_d.ack_vec = st_q.spur;
                ACK_STALE: begin
                    st_d.ack_vec         = st_q.spur;
                    st_d.act_clr[rb_idx] = 1'b1;
                end
                default: begin
                    st_d.ack_vec       = src_vec[int'(rb_idx)*VW +: VW];
                    st_d.insvc[rb_idx] = 1'b1;
                end
            endcase
            if (ack_kind != ACK_EMPTY) begin
                st_d.raised[rb_idx] = 1'b0;
                if (!src_level[rb_idx]) begin
                    st_d.act_clr[rb_idx]  = 1'b1;
                    st_d.pend_clr[rb_idx] = 1'b1;
                end
            end
        end else if (eoi_req) begin
            if (is_found) st_d.insvc[is_idx] = 1'b0;
            if (rb_found && prio_beats(rb_prio, rem_found, rem_prio))
                st_d.irq = 1'b1;
        end

        if (dlv_raise) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.tpr     <= TPR_RST;
            st_q.spur    <= SPUR_RST;
            st_q.ack_vec <= SPUR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o      = st_q.irq;
    assign ack_vld_o  = st_q.ack_vld;
    assign ack_vec_o  = st_q.ack_vec;
    assign act_set_o  = st_q.act_set;
    assign act_clr_o  = st_q.act_clr;
    assign pend_clr_o = st_q.pend_clr;
    assign tpr_o      = st_q.tpr;
    assign spur_o     = st_q.spur;

    // ---------------------------------------------------------------- checks
    logic [N-1:0]  raised_q, insvc_q;
    logic [PW-1:0] tpr_q;
    assign raised_q = st_q.raised;
    assign insvc_q  = st_q.insvc;
    assign tpr_q    = st_q.tpr;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R2
        prio_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            act_set_o[g] |-> ($past(src_prio[g*PW +: PW]) > $past(tpr_q)));
    end

    // R3
    missed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_set_o & $past(raised_q)) == '0);

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((dlv_req != '0) || eoi_req));

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_vld_o);

    // R8
    insvc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(insvc_q) <= $countones($past(insvc_q)) + 1);

    // R9
    pend_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr_o) && ((pend_clr_o & ~act_clr_o) == '0));

    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && (dlv_req == '0)) |=> !irq_o);

    // R11
    eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !ack_req && (insvc_q != '0)) |=>
        ($countones(insvc_q) == $countones($past(insvc_q)) - 1));

    // R12
    tpr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_we |=> (tpr_o == $past(tpr_wdata)));

endmodule

// File: tb/irqarb_cpu_tb.sv
`timescale 1ns/1ps
module irqarb_cpu_tb;
    localparam int N = 16;
    localparam int PW = 4;
    localparam int VW = 8;

    typedef enum logic [1:0] {K_TPR = 2'd0, K_DLV = 2'd1, K_ACK = 2'd2, K_EOI = 2'd3} kind_e;
    typedef struct packed {
        kind_e      kind;
        logic [3:0] src;
        logic [7:0] val;
        logic       e_irq;
        logic       e_flag;
        logic [7:0] e_vec;
        logic [3:0] rid;
    } step_t;

    // kind, src, value, expected irq, expected act_set, expected vector, requirement
    localparam step_t TBL [16] = '{
        '{K_TPR, 4'd0, 8'd3, 1'b0, 1'b0, 8'h00, 4'd12},
        '{K_DLV, 4'd2, 8'd3, 1'b0, 1'b0, 8'h00, 4'd2 },
        '{K_DLV, 4'd2, 8'd4, 1'b1, 1'b1, 8'h00, 4'd2 },
        '{K_DLV, 4'd2, 8'd4, 1'b1, 1'b0, 8'h00, 4'd3 },
        '{K_ACK, 4'd0, 8'd0, 1'b0, 1'b0, 8'h42, 4'd10},
        '{K_DLV, 4'd7, 8'd6, 1'b1, 1'b1, 8'h00, 4'd4 },
        '{K_DLV, 4'd4, 8'd5, 1'b1, 1'b1, 8'h00, 4'd2 },
        '{K_DLV, 4'd9, 8'd6, 1'b1, 1'b1, 8'h00, 4'd2 },
        '{K_ACK, 4'd0, 8'd0, 1'b0, 1'b0, 8'h47, 4'd5 },
        '{K_DLV, 4'd1, 8'd6, 1'b0, 1'b1, 8'h00, 4'd4 },
        '{K_DLV, 4'd3, 8'd7, 1'b1, 1'b1, 8'h00, 4'd4 },
        '{K_ACK, 4'd0, 8'd0, 1'b0, 1'b0, 8'h43, 4'd5 },
        '{K_ACK, 4'd0, 8'd0, 1'b0, 1'b0, 8'h41, 4'd5 },
        '{K_ACK, 4'd0, 8'd0, 1'b0, 1'b0, 8'h49, 4'd5 },
        '{K_ACK, 4'd0, 8'd0, 1'b0, 1'b0, 8'h44, 4'd8 },
        '{K_ACK, 4'd0, 8'd0, 1'b0, 1'b0, 8'hFF, 4'd6 }
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    dlv_req = '0;
    logic [N*PW-1:0] src_prio;
    logic [N*VW-1:0] src_vec;
    logic [N-1:0]    src_level;
    logic [N-1:0]    act_r = '0;
    logic            tpr_we = 1'b0;
    logic [PW-1:0]   tpr_wdata = '0;
    logic            spur_we = 1'b0;
    logic [VW-1:0]   spur_wdata = '0;
    logic            ack_req = 1'b0;
    logic            eoi_req = 1'b0;
    logic            irq_o, ack_vld_o;
    logic [VW-1:0]   ack_vec_o, spur_o;
    logic [N-1:0]    act_set_o, act_clr_o, pend_clr_o;
    logic [PW-1:0]   tpr_o;
    logic [PW-1:0]   bprio [N];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            src_prio[i*PW +: PW] = bprio[i];
            src_vec[i*VW +: VW]  = 8'h40 + 8'(i);
            src_level[i]         = (i == 12);
        end
    end

    irqarb_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .dlv_req(dlv_req), .src_prio(src_prio),
        .src_vec(src_vec), .src_level(src_level), .src_active(act_r),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .spur_we(spur_we),
        .spur_wdata(spur_wdata), .ack_req(ack_req), .eoi_req(eoi_req),
        .irq_o(irq_o), .ack_vld_o(ack_vld_o), .ack_vec_o(ack_vec_o),
        .act_set_o(act_set_o), .act_clr_o(act_clr_o), .pend_clr_o(pend_clr_o),
        .tpr_o(tpr_o), .spur_o(spur_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Let one edge capture the driven strobes, then sample at the next falling edge
    task automatic tick();
        @(negedge clk);
        act_r      = (act_r | act_set_o) & ~act_clr_o;
        dlv_req    = '0;
        ack_req    = 1'b0;
        eoi_req    = 1'b0;
        tpr_we     = 1'b0;
        spur_we    = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        act_r = '0;
        for (int i = 0; i < N; i++) bprio[i] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_tpr(input logic [3:0] v);
        tpr_we = 1'b1; tpr_wdata = v; tick();
    endtask

    task automatic deliver(input int s, input logic [3:0] p);
        bprio[s] = p; dlv_req[s] = 1'b1; tick();
    endtask

    task automatic ack(input string tag, input logic [7:0] exp_vec);
        ack_req = 1'b1; tick();
        chk({tag, " ack valid"}, 32'(ack_vld_o), 32'd1);
        chk({tag, " ack vector"}, 32'(ack_vec_o), 32'(exp_vec));
    endtask

    task automatic eoi();
        eoi_req = 1'b1; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 irq", 32'(irq_o), 32'd0);
        chk("R1 ack_vld", 32'(ack_vld_o), 32'd0);
        chk("R1 tpr", 32'(tpr_o), 32'd15);
        chk("R1 spur", 32'(spur_o), 32'hFF);
        deliver(0, 4'd15);
        chk("R1 R2 prio 15 vs tpr 15 dropped", 32'(act_set_o[0]), 32'd0);
        ack("R1 empty", 8'hFF);

        // Table walk
        for (int k = 0; k < 16; k++) begin
            step_t e = TBL[k];
            string tg = $sformatf("R%0d step %0d", e.rid, k);
            case (e.kind)
                K_TPR: begin
                    set_tpr(e.val[3:0]);
                    chk({tg, " tpr"}, 32'(tpr_o), 32'(e.val[3:0]));
                end
                K_DLV: begin
                    deliver(int'(e.src), e.val[3:0]);
                    chk({tg, " act_set"}, 32'(act_set_o[e.src]), 32'(e.e_flag));
                end
                K_ACK: ack(tg, e.e_vec);
                default: eoi();
            endcase
            chk({tg, " irq"}, 32'(irq_o), 32'(e.e_irq));
        end

        // R12 spurious vector write, R6 empty acknowledge returns it
        do_reset();
        spur_we = 1'b1; spur_wdata = 8'h3C; tick();
        chk("R12 spur", 32'(spur_o), 32'h3C);
        ack("R6 empty after write", 8'h3C);

        // R7 stale by threshold
        do_reset();
        set_tpr(4'd0);
        deliver(5, 4'd4);
        chk("R7 irq up", 32'(irq_o), 32'd1);
        set_tpr(4'd4);
        ack("R7 threshold stale", 8'hFF);
        chk("R7 act_clr", 32'(act_clr_o[5]), 32'd1);
        chk("R10 irq down", 32'(irq_o), 32'd0);
        set_tpr(4'd0);
        deliver(5, 4'd4);
        chk("R7 raised bit cleared", 32'(act_set_o[5]), 32'd1);
        ack("R8 after stale", 8'h45);

        // R7 stale by inactive flag
        deliver(6, 4'd2);
        act_r[6] = 1'b0;
        ack("R7 inactive stale", 8'hFF);
        chk("R7 inactive act_clr", 32'(act_clr_o[6]), 32'd1);

        // R9 level versus edge
        deliver(12, 4'd5);
        ack("R9 level", 8'h4C);
        chk("R9 level act_clr", 32'(act_clr_o[12]), 32'd0);
        chk("R9 level pend_clr", 32'(pend_clr_o[12]), 32'd0);
        deliver(13, 4'd5);
        ack("R9 edge", 8'h4D);
        chk("R9 edge act_clr", 32'(act_clr_o[13]), 32'd1);
        chk("R9 edge pend_clr", 32'(pend_clr_o[13]), 32'd1);

        // R11 end-of-interrupt ordering and re-raise
        do_reset();
        set_tpr(4'd0);
        deliver(3, 4'd9);
        ack("R11 setup s3", 8'h43);
        deliver(5, 4'd4);
        ack("R11 setup s5", 8'h45);
        bprio[7] = 4'd6; bprio[8] = 4'd6;
        dlv_req[7] = 1'b1; dlv_req[8] = 1'b1; tick();
        chk("R4 pair raises", 32'(irq_o), 32'd1);
        ack("R5 tie picks s7", 8'h47);
        eoi();
        chk("R11 first eoi no re-raise", 32'(irq_o), 32'd0);
        eoi();
        chk("R11 second eoi re-raise", 32'(irq_o), 32'd1);
        ack("R11 queued s8", 8'h48);
        eoi();
        chk("R11 third eoi idle", 32'(irq_o), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule